// File: doc/BRIEF.md
# Interrupt Trigger and End-of-Interrupt Controller

This block sits next to an interrupt routing table and decides, pin by pin, when a request goes out for delivery. It watches each pin's input line. It takes the per-pin fields it needs from the table: mask, trigger kind and vector. It also receives end-of-interrupt (EOI) messages that carry a vector. For every pin it holds a remote IRR bit, which records that a level-triggered interrupt is in service and has not yet been acknowledged.

Requests from many pins are turned into one stream of single-pin requests. Each request carries a pin index and a valid flag, and a downstream dispatcher accepts it with a ready signal. When several pins are waiting, the lowest index is served first. Each pin has a pending flag, so events on a pin that has not yet been served merge into one request.

The arbiter is a two-state machine. `ARB_IDLE` presents nothing. `ARB_OFFER` presents one registered pin index. There are four transitions:
- load: `ARB_IDLE` to `ARB_OFFER` when any pin is pending.
- hold: stay in `ARB_OFFER` while ready is low.
- advance: stay in `ARB_OFFER`, showing the next lowest pending pin, on a handshake when more pins wait.
- drain: `ARB_OFFER` to `ARB_IDLE` on a handshake with nothing else pending.

Top module: `irq_trigger_ctl`

## Requirements
- R1: A rising edge on a pin whose mask bit is 1 produces no request and leaves that pin's remote IRR unchanged. Changing a mask bit alone never produces a request.
- R2: An unmasked edge-triggered pin (trigger bit 0) produces one request for each rising edge, whatever its remote IRR holds. The request becomes visible after the second clock edge following the rise.
- R3: An unmasked level-triggered pin (trigger bit 1) produces a request on a rising edge only while its remote IRR is 0, and sets remote IRR when it does. Remote IRR is never set on a masked pin or on an edge-triggered pin.
- R4: An EOI clears remote IRR only in the lowest-numbered pin whose vector field equals the EOI vector. An EOI that matches no pin changes nothing. Remote IRR is cleared only by an EOI.
- R5: When an EOI selects a pin that is level-triggered and unmasked and whose line is still 1, remote IRR stays set and a new request is produced.
- R6: A write strobe for the lower half of a pin's entry produces a request, and sets remote IRR, when that pin is level-triggered, unmasked, has remote IRR 0 and its line is 1.
- R7: Pending pins are presented lowest index first, one per cycle while ready is 1. While ready is 0, valid stays 1 and the pin index stays stable.
- R8: After reset, valid is 0 and every remote IRR bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_i | input | NPINS | Current state of each interrupt line |
| mask_i | input | NPINS | Per-pin mask from the table, 1 = masked |
| level_i | input | NPINS | Per-pin trigger kind, 1 = level, 0 = edge |
| vec_i | input | NPINS*VW | Per-pin vector fields, pin i at bits [i*VW +: VW] |
| eoi_valid_i | input | 1 | End-of-interrupt message present this cycle |
| eoi_vec_i | input | VW | Vector carried by the EOI |
| lo_wr_i | input | 1 | Software wrote the lower half of an entry |
| lo_wr_idx_i | input | PW | Pin index of that write |
| req_valid_o | output | 1 | A delivery request is presented |
| req_pin_o | output | PW | Pin index of the presented request |
| req_ready_i | input | 1 | Dispatcher accepts the request this cycle |
| rirr_o | output | NPINS | Remote IRR bit of each pin |

## Verification
The assertions watch, on every cycle, that a presented request holds its pin until it is accepted and that the pin index stays in range. They also check that remote IRR only ever rises on unmasked level-triggered pins and only ever falls in the cycle after an EOI. Only the bench scenarios can show the rest:
- which pin an EOI with a duplicated vector actually selects;
- that requests re-fire after an EOI or a lower-half write;
- that an edge-triggered pin fires again while its remote IRR is set;
- the exact ascending order in which several simultaneous requests leave the block.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;

    typedef enum logic [0:0] {
        ARB_IDLE  = 1'b0,
        ARB_OFFER = 1'b1
    } arb_state_e;

endpackage

// File: rtl/irq_pin_slice.sv
module irq_pin_slice (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic mask_i,
    input  logic level_i,
    input  logic eoi_hit_i,
    input  logic wr_hit_i,
    input  logic grant_i,
    output logic pend_o,
    output logic rirr_o
);

    logic line_q;
    logic pend_q;
    logic rirr_q;
    logic rise;
    logic fire_edge;
    logic fire_lvl;
    logic fire_eoi;
    logic fire_wr;
    logic fire;

    // Edges are taken against the registered copy; level checks use the live line
    assign rise      = line_i & ~line_q;
    assign fire_edge = ~mask_i & rise & ~level_i;
    assign fire_lvl  = ~mask_i & rise &  level_i & ~rirr_q;
    assign fire_eoi  = eoi_hit_i & level_i & ~mask_i & line_i;
    assign fire_wr   = wr_hit_i  & level_i & ~mask_i & ~rirr_q & line_i;
    assign fire      = fire_edge | fire_lvl | fire_eoi | fire_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= 1'b0;
            pend_q <= 1'b0;
            rirr_q <= 1'b0;
        end else begin
            line_q <= line_i;
            // a new event outranks the grant clearing the flag
            pend_q <= fire | (pend_q & ~grant_i);
            rirr_q <= (rirr_q & ~eoi_hit_i) | fire_lvl | fire_eoi | fire_wr;
        end
    end

    assign pend_o = pend_q;
    assign rirr_o = rirr_q;

endmodule

// File: rtl/irq_eoi_match.sv
module irq_eoi_match #(
    parameter int NPINS = 8,
    parameter int VW    = 8
) (
    input  logic [NPINS*VW-1:0] vec_i,
    input  logic                eoi_valid_i,
    input  logic [VW-1:0]       eoi_vec_i,
    output logic [NPINS-1:0]    hit_o
);

    localparam logic [NPINS-1:0] ONE = {{(NPINS-1){1'b0}}, 1'b1};

    logic [NPINS-1:0] match;

    for (genvar g = 0; g < NPINS; g++) begin : g_cmp
        assign match[g] = eoi_valid_i && (vec_i[g*VW +: VW] == eoi_vec_i);
    end

    // isolate the lowest set bit: lowest-numbered matching entry wins
    assign hit_o = match & (~match + ONE);

endmodule

// File: rtl/irq_grant_fsm.sv
module irq_grant_fsm
    import irq_trig_pkg::*;
#(
    parameter int NPINS = 8,
    localparam int PW   = $clog2(NPINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pend_i,
    input  logic             ready_i,
    output logic             valid_o,
    output logic [PW-1:0]    pin_o,
    output logic [NPINS-1:0] grant_o
);

    arb_state_e       state_q, state_d;
    logic [PW-1:0]    pin_q, pin_d;
    logic [NPINS-1:0] remaining;
    logic [PW-1:0]    low;
    logic             any;
    logic             take;

    assign take = (state_q == ARB_OFFER) && ready_i;

    for (genvar g = 0; g < NPINS; g++) begin : g_grant
        assign grant_o[g] = take && (pin_q == PW'(g));
    end

    assign remaining = pend_i & ~grant_o;
    assign any       = |remaining;

    always_comb begin
        low = '0;
        for (int i = NPINS - 1; i >= 0; i--) begin
            if (remaining[i]) low = PW'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            pin_q   <= '0;
        end else begin
            state_q <= state_d;
            pin_q   <= pin_d;
        end
    end

    always_comb begin
        state_d = state_q;
        pin_d   = pin_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (any) begin            // load
                    state_d = ARB_OFFER;
                    pin_d   = low;
                end
            end
            ARB_OFFER: begin
                if (ready_i) begin
                    if (any) pin_d = low; // advance
                    else state_d = ARB_IDLE; // drain
                end                       // else hold
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ARB_OFFER: valid_o = 1'b1;
            default:   valid_o = 1'b0;
        endcase
        pin_o = pin_q;
    end

endmodule

// File: rtl/irq_trigger_ctl.sv
module irq_trigger_ctl #(
    parameter int NPINS = 8,
    parameter int VW    = 8,
    localparam int PW   = $clog2(NPINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NPINS-1:0]    line_i,
    input  logic [NPINS-1:0]    mask_i,
    input  logic [NPINS-1:0]    level_i,
    input  logic [NPINS*VW-1:0] vec_i,
    input  logic                eoi_valid_i,
    input  logic [VW-1:0]       eoi_vec_i,
    input  logic                lo_wr_i,
    input  logic [PW-1:0]       lo_wr_idx_i,
    output logic                req_valid_o,
    output logic [PW-1:0]       req_pin_o,
    input  logic                req_ready_i,
    output logic [NPINS-1:0]    rirr_o
);

    logic [NPINS-1:0] eoi_hit;
    logic [NPINS-1:0] wr_hit;
    logic [NPINS-1:0] pend_q;
    logic [NPINS-1:0] grant;

    irq_eoi_match #(.NPINS(NPINS), .VW(VW)) u_match (
        .vec_i       (vec_i),
        .eoi_valid_i (eoi_valid_i),
        .eoi_vec_i   (eoi_vec_i),
        .hit_o       (eoi_hit)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        assign wr_hit[g] = lo_wr_i && (lo_wr_idx_i == PW'(g));

        irq_pin_slice u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .line_i    (line_i[g]),
            .mask_i    (mask_i[g]),
            .level_i   (level_i[g]),
            .eoi_hit_i (eoi_hit[g]),
            .wr_hit_i  (wr_hit[g]),
            .grant_i   (grant[g]),
            .pend_o    (pend_q[g]),
            .rirr_o    (rirr_o[g])
        );
    end

    irq_grant_fsm #(.NPINS(NPINS)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_i  (pend_q),
        .ready_i (req_ready_i),
        .valid_o (req_valid_o),
        .pin_o   (req_pin_o),
        .grant_o (grant)
    );

endmodule

// File: rtl/irq_trigger_chk.sv
module irq_trigger_chk #(
    parameter int NPINS = 8,
    parameter int PW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid_o,
    input logic             req_ready_i,
    input logic [PW-1:0]    req_pin_o,
    input logic [NPINS-1:0] rirr_o,
    input logic [NPINS-1:0] mask_i,
    input logic [NPINS-1:0] level_i,
    input logic             eoi_valid_i
);

    // R7: an unaccepted request keeps its pin
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_pin_o)));

    // R7: presented index names a real pin
    a_r7_pin_range: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> (int'(req_pin_o) < NPINS));

    // R1: remote IRR never rises on a masked pin
    a_r1_masked_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rirr_o & ~$past(rirr_o) & $past(mask_i)) == '0));

    // R3: remote IRR rises only on level-triggered pins
    a_r3_level_only: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rirr_o & ~$past(rirr_o) & ~$past(level_i)) == '0));

    // R4: remote IRR falls only after an EOI
    a_r4_clear_by_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~rirr_o & $past(rirr_o))) |-> $past(eoi_valid_i));

endmodule

bind irq_trigger_ctl irq_trigger_chk #(.NPINS(NPINS), .PW(PW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_o (req_valid_o),
    .req_ready_i (req_ready_i),
    .req_pin_o   (req_pin_o),
    .rirr_o      (rirr_o),
    .mask_i      (mask_i),
    .level_i     (level_i),
    .eoi_valid_i (eoi_valid_i)
);

// File: tb/sim_irq_trigger_ctl.sv
module sim_irq_trigger_ctl;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int VW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  line = '0, mask = '0, level = '0;
    logic [VW-1:0] vec [N];
    logic [N*VW-1:0] vec_flat;
    logic          eoi_v = 1'b0;
    logic [VW-1:0] eoi_vec = '0;
    logic          wr_v = 1'b0;
    logic [2:0]    wr_idx = '0;
    logic          ready = 1'b1;
    logic          req_valid;
    logic [2:0]    req_pin;
    logic [N-1:0]  rirr;

    int errors = 0;
    int checks = 0;
    logic [N-1:0] rirr_m = '0;
    logic [N-1:0] lq_m = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) vec_flat[i*VW +: VW] = vec[i];
    end

    irq_trigger_ctl #(.NPINS(N), .VW(VW)) u0 (
        .clk(clk), .rst_n(rst_n), .line_i(line), .mask_i(mask), .level_i(level),
        .vec_i(vec_flat), .eoi_valid_i(eoi_v), .eoi_vec_i(eoi_vec),
        .lo_wr_i(wr_v), .lo_wr_idx_i(wr_idx), .req_valid_o(req_valid),
        .req_pin_o(req_pin), .req_ready_i(ready), .rirr_o(rirr)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected set of firing pins, and the next remote IRR, from the requirements
    function automatic logic [N-1:0] fired(input logic [N-1:0] ln, mk, lv,
            input bit ev, input logic [VW-1:0] evec, input bit wv,
            input logic [2:0] widx, output logic [N-1:0] rirr_next);
        logic [N-1:0] f;
        int hit;
        hit = -1;
        if (ev) for (int i = N - 1; i >= 0; i--) if (vec[i] == evec) hit = i;
        f = '0;
        rirr_next = rirr_m;
        for (int i = 0; i < N; i++) begin
            bit rise, fe, fl, fo, fw;
            rise = ln[i] && !lq_m[i];
            fe = !mk[i] && rise && !lv[i];                          // R2
            fl = !mk[i] && rise && lv[i] && !rirr_m[i];             // R3
            fo = (hit == i) && lv[i] && !mk[i] && ln[i];            // R5
            fw = wv && (widx == i) && lv[i] && !mk[i] && !rirr_m[i] && ln[i]; // R6
            if (hit == i) rirr_next[i] = 1'b0;                      // R4
            if (fl || fo || fw) rirr_next[i] = 1'b1;
            f[i] = fe || fl || fo || fw;
        end
        return f;
    endfunction

    task automatic round(input logic [N-1:0] ln, mk, lv, input bit ev,
            input logic [VW-1:0] evec, input bit wv, input logic [2:0] widx,
            input string tag);
        logic [N-1:0] exp_f, rn;
        int got [16];
        int ng, ne;
        bit ok;
        exp_f = fired(ln, mk, lv, ev, evec, wv, widx, rn);
        line = ln; mask = mk; level = lv;
        eoi_v = ev; eoi_vec = evec; wr_v = wv; wr_idx = widx; ready = 1'b1;
        ng = 0;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            if (k == 0) begin eoi_v = 1'b0; wr_v = 1'b0; end
            if (req_valid && ready && ng < 16) begin got[ng] = int'(req_pin); ng++; end
        end
        rirr_m = rn;
        lq_m = ln;
        check(rirr == rirr_m, {tag, " remote IRR"}, int'(rirr), int'(rirr_m));
        ne = $countones(exp_f);
        ok = (ng == ne);
        if (ok) begin
            int j;
            j = 0;
            for (int i = 0; i < N; i++) if (exp_f[i]) begin
                if (got[j] != i) ok = 1'b0;
                j++;
            end
        end
        check(ok, {tag, " request order (R7)"}, ng, ne);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) vec[i] = 8'h40 + 8'(i);
        vec[3] = 8'h55; vec[6] = 8'h55;
        repeat (3) @(negedge clk);
        check(req_valid == 1'b0, "R8 valid after reset", int'(req_valid), 0);
        check(rirr == '0, "R8 remote IRR after reset", int'(rirr), 0);
        rst_n = 1'b1;
        @(negedge clk);

        round(8'h01, 8'h01, 8'h00, 0, 0, 0, 0, "R1 masked edge");
        round(8'h00, 8'h00, 8'h00, 0, 0, 0, 0, "R1 mask cleared");
        round(8'h02, 8'h00, 8'h02, 0, 0, 0, 0, "R3 level fires");
        round(8'h00, 8'h00, 8'h00, 0, 0, 0, 0, "R2 line low");
        round(8'h02, 8'h00, 8'h00, 0, 0, 0, 0, "R2 edge with IRR set");
        round(8'h00, 8'h00, 8'h02, 0, 0, 0, 0, "R3 line low");
        round(8'h02, 8'h00, 8'h02, 0, 0, 0, 0, "R3 gated by IRR");
        round(8'h02, 8'h00, 8'h02, 1, 8'h41, 0, 0, "R5 EOI refire");
        round(8'h00, 8'h00, 8'h02, 1, 8'h41, 0, 0, "R4 EOI clears");
        round(8'h48, 8'h00, 8'h48, 0, 0, 0, 0, "R3 pins 3 and 6");
        round(8'h00, 8'h00, 8'h48, 1, 8'h99, 0, 0, "R4 unmatched EOI");
        round(8'h00, 8'h00, 8'h48, 1, 8'h55, 0, 0, "R4 lowest match");
        round(8'h10, 8'h10, 8'h10, 0, 0, 0, 0, "R1 masked level");
        round(8'h10, 8'h00, 8'h10, 0, 0, 0, 0, "R1 unmask alone");
        round(8'h10, 8'h00, 8'h10, 0, 0, 1, 3'd4, "R6 lower write");
        round(8'h00, 8'h00, 8'h00, 1, 8'h44, 0, 0, "R4 release");
        round(8'hA1, 8'h00, 8'h00, 0, 0, 0, 0, "R7 three pins");
        round(8'h00, 8'h00, 8'h00, 0, 0, 0, 0, "R7 idle");

        // R7 backpressure: pins 5 and 2 pend while ready is low
        ready = 1'b0; line = 8'h24;
        repeat (3) @(negedge clk);
        check(req_valid && req_pin == 3'd2, "R7 lowest offered", int'(req_pin), 2);
        repeat (2) @(negedge clk);
        check(req_valid && req_pin == 3'd2, "R7 held under stall", int'(req_pin), 2);
        ready = 1'b1;
        @(negedge clk);
        check(req_valid && req_pin == 3'd5, "R7 next pin", int'(req_pin), 5);
        @(negedge clk);
        check(!req_valid, "R7 drained", int'(req_valid), 0);
        lq_m = line;

        for (int r = 0; r < 60; r++) begin
            for (int i = 0; i < N; i++) vec[i] = 8'h40 + 8'($urandom % 8);
            round(8'($urandom), 8'($urandom & $urandom), 8'($urandom),
                  1'($urandom), 8'h40 + 8'($urandom % 10),
                  1'($urandom), 3'($urandom), "R2 R3 R4 R5 R6 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule